// File: doc/BRIEF.md
# Four-Thread Synchronous Slave FIFO Endpoint

This block is the device side of a synchronous parallel FIFO port. An external master selects one of four threads with a 2-bit address. It moves words with chip-select, read, write and output-enable strobes. Each thread has its own direction, fixed by a parameter, and its own small packet buffer. A read thread carries data from the chip to the master. A write thread carries data from the master into the chip. Inside the chip, each thread has a valid/ready stream. Read threads are filled through it and write threads are drained through it.

Two status outputs tell the master when it may access a thread. Each output is bound by parameter either to a fixed thread or to whichever thread is addressed. Each reports either plain availability (not empty / not full) or a watermark level. The address goes through a three-stage register pipeline before it selects anything, so the data bus and the addressed-thread status follow an address change three clock edges later. The data bus is modelled as a separate driven value plus a drive-enable output, not as a tri-state pin.

Top module: `slave_fifo_endpoint`

## Requirements
- R1: The thread used for master accesses, for the data bus and for any status output that follows the address is the `addr` value sampled three rising clock edges earlier.
- R2: Bit i of parameter THREAD_IS_RD set to 1 makes thread i a read thread (default 4'b0101). With `cs_n`=0 and `rd_n`=0, one word is removed from the current read thread at the clock edge. `dout` shows the oldest word of the current thread when that thread is a read thread, holds data and the bus is enabled; otherwise `dout` is zero.
- R3: With `cs_n`=0 and `wr_n`=0, `din` is appended at the clock edge to the current thread when it is a write thread with free space.
- R4: In availability mode a status output is 1 when its read thread holds at least one word, or when its write thread has at least one free slot. Otherwise it is 0, meaning empty or full.
- R5: In watermark mode a status output is 1 when the word count (read thread) or the free slot count (write thread) is at least WMARK (default 3), and 0 otherwise.
- R6: `flag0` follows the current thread in availability mode by default. `flag1` is fixed to thread 1 in watermark mode by default and does not depend on `addr`.
- R7: A read strobe on an empty thread or on a write thread has no effect on any buffer and sets `err_sticky[thread]`. The same holds for a write strobe on a full thread or on a read thread. Error bits clear only on reset.
- R8: `dout_en` is 1 exactly when `cs_n` and `oe_n` are both 0.
- R9: While `rst_n` is low, all buffers are empty, `err_sticky` is 0 and the address pipeline holds thread 0.
- R10: `ep_in_ready[i]` is 1 only for a read thread that is not full. `ep_out_valid[i]` is 1 only for a write thread that is not empty, and it comes with that thread's oldest word on `ep_out_data[i*DW +: DW]`.
- R11: Each thread is first-in first-out with a capacity of DEPTH words (default 8). A push and a pop in the same cycle are both honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Thread select from the master |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | DW | Write data from the master |
| dout | output | DW | Read data towards the master |
| dout_en | output | 1 | Drive enable for `dout` |
| flag0 | output | 1 | First status output |
| flag1 | output | 1 | Second status output |
| err_sticky | output | 4 | Per-thread sticky access error |
| ep_in_valid | input | 4 | Internal fill valid per thread |
| ep_in_data | input | 4*DW | Internal fill data, thread i in slice i |
| ep_in_ready | output | 4 | Internal fill ready per thread |
| ep_out_valid | output | 4 | Internal drain valid per thread |
| ep_out_data | output | 4*DW | Internal drain data, thread i in slice i |
| ep_out_ready | input | 4 | Internal drain ready per thread |

## Verification
Assertions run on every cycle. They check that the current thread equals the address from three edges back and that error bits never fall. They also check that a bad read always raises its error bit, and that no buffer is pushed while full or popped while empty, with its count tracking single pushes. Only the bench scenarios can show the rest, using a reference model of the queues. That covers whether the data bus and both status outputs carry the right word and level per thread and mode, that word order survives fills and drains, and that overflow and underflow leave buffer contents untouched.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int NUM_THREADS = 4;
  localparam int THREAD_W    = 2;
  localparam int ADDR_LAT    = 3;

  typedef enum logic {
    FLAG_AVAIL     = 1'b0,
    FLAG_WATERMARK = 1'b1
  } flag_mode_e;
endpackage

// File: rtl/sfifo_thread_buf.sv
module sfifo_thread_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = wp_q + PW'(1);
    if (pop)  rp_d = rp_q + PW'(1);
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= push_data;
  end

  assign head  = mem_q[rp_q];
  assign count = cnt_q;

  // R11: the owner logic never pushes into a full buffer
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != FULL_CNT));
  // R11: the owner logic never pops an empty buffer
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  // R11: a lone push raises the count by one
  a_r11_count_track: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/sfifo_flag_gen.sv
module sfifo_flag_gen
  import sfifo_pkg::*;
#(
  parameter int                     DEPTH  = 8,
  parameter int                     WMARK  = 3,
  parameter logic [NUM_THREADS-1:0] IS_RD  = 4'b0101,
  parameter flag_mode_e             MODE   = FLAG_AVAIL,
  parameter bit                     FOLLOW = 1'b1,
  parameter int                     FIXED  = 0
) (
  input  logic [NUM_THREADS*$clog2(DEPTH+1)-1:0] cnt_flat,
  input  logic [THREAD_W-1:0]                    cur,
  output logic                                   flag
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0]       FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0]       WM_CNT   = CW'(WMARK);
  localparam logic [THREAD_W-1:0] FIXED_T  = THREAD_W'(FIXED);

  logic [THREAD_W-1:0] sel;
  logic [CW-1:0]       sel_cnt, level;

  generate
    if (FOLLOW) begin : g_follow
      assign sel = cur;
    end else begin : g_fixed
      assign sel = FIXED_T;
    end
  endgenerate

  always_comb begin
    sel_cnt = cnt_flat[sel*CW +: CW];
    level   = IS_RD[sel] ? sel_cnt : (FULL_CNT - sel_cnt);
    if (MODE == FLAG_AVAIL) flag = (level != '0);
    else                    flag = (level >= WM_CNT);
  end
endmodule

// File: rtl/slave_fifo_endpoint.sv
module slave_fifo_endpoint
  import sfifo_pkg::*;
#(
  parameter int                     DW           = 32,
  parameter int                     DEPTH        = 8,
  parameter int                     WMARK        = 3,
  parameter logic [NUM_THREADS-1:0] THREAD_IS_RD = 4'b0101,
  parameter flag_mode_e             F0_MODE      = FLAG_AVAIL,
  parameter bit                     F0_FOLLOW    = 1'b1,
  parameter int                     F0_THREAD    = 0,
  parameter flag_mode_e             F1_MODE      = FLAG_WATERMARK,
  parameter bit                     F1_FOLLOW    = 1'b0,
  parameter int                     F1_THREAD    = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  addr,
  input  logic                        cs_n,
  input  logic                        rd_n,
  input  logic                        wr_n,
  input  logic                        oe_n,
  input  logic [DW-1:0]               din,
  output logic [DW-1:0]               dout,
  output logic                        dout_en,
  output logic                        flag0,
  output logic                        flag1,
  output logic [3:0]                  err_sticky,
  input  logic [3:0]                  ep_in_valid,
  input  logic [4*DW-1:0]             ep_in_data,
  output logic [3:0]                  ep_in_ready,
  output logic [3:0]                  ep_out_valid,
  output logic [4*DW-1:0]             ep_out_data,
  input  logic [3:0]                  ep_out_ready
);
  localparam int NT = NUM_THREADS;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // address pipeline
  logic [THREAD_W-1:0] ap_q [ADDR_LAT];
  logic [THREAD_W-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ADDR_LAT; k++) ap_q[k] <= '0;
    end else begin
      ap_q[0] <= addr;
      for (int k = 1; k < ADDR_LAT; k++) ap_q[k] <= ap_q[k-1];
    end
  end
  assign cur = ap_q[ADDR_LAT-1];

  // master strobes
  logic          rd_req, wr_req, rd_ok, wr_ok, cur_is_rd;
  logic [CW-1:0] cnt [NT];
  logic [DW-1:0] head [NT];
  logic [CW-1:0] cnt_cur;
  logic [DW-1:0] head_cur;
  logic [NT*CW-1:0] cnt_flat;

  always_comb begin
    rd_req    = !cs_n && !rd_n;
    wr_req    = !cs_n && !wr_n;
    cnt_cur   = cnt[cur];
    head_cur  = head[cur];
    cur_is_rd = THREAD_IS_RD[cur];
    rd_ok     = rd_req &&  cur_is_rd && (cnt_cur != '0);
    wr_ok     = wr_req && !cur_is_rd && (cnt_cur != FULL_CNT);
  end

  // per-thread buffers and internal streams
  logic [NT-1:0] push, pop;
  logic [DW-1:0] push_data [NT];

  genvar gi;
  generate
    for (gi = 0; gi < NT; gi++) begin : g_thr
      if (THREAD_IS_RD[gi]) begin : g_rd
        assign ep_in_ready[gi]            = (cnt[gi] != FULL_CNT);
        assign push[gi]                   = ep_in_valid[gi] && ep_in_ready[gi];
        assign push_data[gi]              = ep_in_data[gi*DW +: DW];
        assign pop[gi]                    = rd_ok && (cur == THREAD_W'(gi));
        assign ep_out_valid[gi]           = 1'b0;
        assign ep_out_data[gi*DW +: DW]   = '0;
      end else begin : g_wr
        assign ep_in_ready[gi]            = 1'b0;
        assign push[gi]                   = wr_ok && (cur == THREAD_W'(gi));
        assign push_data[gi]              = din;
        assign ep_out_valid[gi]           = (cnt[gi] != '0);
        assign pop[gi]                    = ep_out_valid[gi] && ep_out_ready[gi];
        assign ep_out_data[gi*DW +: DW]   = head[gi];
      end

      sfifo_thread_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push[gi]),
        .push_data (push_data[gi]),
        .pop       (pop[gi]),
        .head      (head[gi]),
        .count     (cnt[gi])
      );

      assign cnt_flat[gi*CW +: CW] = cnt[gi];
    end
  endgenerate

  // sticky errors
  logic [NT-1:0] err_q, err_d, cur_oh;

  always_comb begin
    cur_oh = NT'(1) << cur;
    err_d  = err_q;
    if ((rd_req && !rd_ok) || (wr_req && !wr_ok)) err_d = err_q | cur_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end
  assign err_sticky = err_q;

  // data bus
  always_comb begin
    dout_en = !cs_n && !oe_n;
    dout    = (dout_en && cur_is_rd && (cnt_cur != '0)) ? head_cur : '0;
  end

  // status outputs
  sfifo_flag_gen #(
    .DEPTH(DEPTH), .WMARK(WMARK), .IS_RD(THREAD_IS_RD),
    .MODE(F0_MODE), .FOLLOW(F0_FOLLOW), .FIXED(F0_THREAD)
  ) u_flag0 (.cnt_flat(cnt_flat), .cur(cur), .flag(flag0));

  sfifo_flag_gen #(
    .DEPTH(DEPTH), .WMARK(WMARK), .IS_RD(THREAD_IS_RD),
    .MODE(F1_MODE), .FOLLOW(F1_FOLLOW), .FIXED(F1_THREAD)
  ) u_flag1 (.cnt_flat(cnt_flat), .cur(cur), .flag(flag1));

  // R1: selected thread lags the address by three edges
  a_r1_addr_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3)) |-> (cur == $past(addr, 3)));
  // R7: error bits never fall while out of reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q & $past(err_q)) == $past(err_q)));
  // R7: reading an empty thread flags that thread
  a_r7_bad_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (cnt_cur == '0)) |=> err_q[$past(cur)]);
endmodule

// File: tb/sim_slave_fifo_endpoint.sv
module sim_slave_fifo_endpoint;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int WMARK = 3;
  localparam logic [3:0] IS_RD = 4'b0101;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic [1:0]     addr;
  logic           cs_n, rd_n, wr_n, oe_n;
  logic [DW-1:0]  din, dout;
  logic           dout_en, flag0, flag1;
  logic [3:0]     err_sticky, ep_in_valid, ep_in_ready, ep_out_valid, ep_out_ready;
  logic [4*DW-1:0] ep_in_data, ep_out_data;

  slave_fifo_endpoint u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en), .flag0(flag0),
    .flag1(flag1), .err_sticky(err_sticky), .ep_in_valid(ep_in_valid),
    .ep_in_data(ep_in_data), .ep_in_ready(ep_in_ready), .ep_out_valid(ep_out_valid),
    .ep_out_data(ep_out_data), .ep_out_ready(ep_out_ready)
  );

  int vectors = 0;
  int miscompares = 0;

  // reference model
  logic [DW-1:0] mq [4][DEPTH];
  int            mcnt [4];
  logic [3:0]    merr;
  logic [1:0]    mp [3];

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 4; t++) mcnt[t] = 0;
    merr = '0;
    for (int k = 0; k < 3; k++) mp[k] = '0;
  endtask

  function automatic logic exp_flag(input bit wm, input int t);
    int level;
    level = IS_RD[t] ? mcnt[t] : (DEPTH - mcnt[t]);
    return wm ? (level >= WMARK) : (level != 0);
  endfunction

  function automatic logic [DW-1:0] exp_dout();
    int t;
    t = int'(mp[2]);
    if (!cs_n && !oe_n && IS_RD[t] && mcnt[t] > 0) return mq[t][0];
    return '0;
  endfunction

  task automatic model_edge();
    int  e;
    bit  rq, wq;
    bit  pu [4];
    bit  po [4];
    logic [DW-1:0] pd [4];
    e  = int'(mp[2]);
    rq = !cs_n && !rd_n;
    wq = !cs_n && !wr_n;
    if (rq && !(IS_RD[e] && mcnt[e] > 0)) merr[e] = 1'b1;
    if (wq && !(!IS_RD[e] && mcnt[e] < DEPTH)) merr[e] = 1'b1;
    for (int t = 0; t < 4; t++) begin
      if (IS_RD[t]) begin
        po[t] = rq && (e == t) && mcnt[t] > 0;
        pu[t] = ep_in_valid[t] && mcnt[t] < DEPTH;
        pd[t] = ep_in_data[t*DW +: DW];
      end else begin
        po[t] = ep_out_ready[t] && mcnt[t] > 0;
        pu[t] = wq && (e == t) && mcnt[t] < DEPTH;
        pd[t] = din;
      end
    end
    for (int t = 0; t < 4; t++) begin
      if (po[t]) begin
        for (int k = 0; k < DEPTH - 1; k++) mq[t][k] = mq[t][k+1];
        mcnt[t]--;
      end
      if (pu[t]) begin
        mq[t][mcnt[t]] = pd[t];
        mcnt[t]++;
      end
    end
    mp[2] = mp[1];
    mp[1] = mp[0];
    mp[0] = addr;
  endtask

  task automatic check_all(input string ph);
    chk(dout_en == (!cs_n && !oe_n), {ph, " R8 dout_en"}, DW'(dout_en), DW'(!cs_n && !oe_n));
    chk(dout == exp_dout(), {ph, " R2 R1 dout"}, dout, exp_dout());
    chk(flag0 == exp_flag(1'b0, int'(mp[2])), {ph, " R4 R1 flag0"}, DW'(flag0), DW'(exp_flag(1'b0, int'(mp[2]))));
    chk(flag1 == exp_flag(1'b1, 1), {ph, " R5 R6 flag1"}, DW'(flag1), DW'(exp_flag(1'b1, 1)));
    chk(err_sticky == merr, {ph, " R7 err_sticky"}, DW'(err_sticky), DW'(merr));
    for (int t = 0; t < 4; t++) begin
      logic er, ev;
      er = IS_RD[t] && mcnt[t] < DEPTH;
      ev = !IS_RD[t] && mcnt[t] > 0;
      chk(ep_in_ready[t] == er, {ph, " R10 ep_in_ready"}, DW'(ep_in_ready[t]), DW'(er));
      chk(ep_out_valid[t] == ev, {ph, " R10 ep_out_valid"}, DW'(ep_out_valid[t]), DW'(ev));
      if (ev) chk(ep_out_data[t*DW +: DW] == mq[t][0], {ph, " R3 R11 ep_out_data"},
                  ep_out_data[t*DW +: DW], mq[t][0]);
    end
  endtask

  task automatic step(input string ph);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(ph);
  endtask

  task automatic idle_inputs();
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; oe_n = 1'b1;
    din = '0; ep_in_valid = '0; ep_in_data = '0; ep_out_ready = '0;
  endtask

  function automatic bit pick(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic random_phase(input int n, input int p_rd, input int p_wr, input int p_in, input int p_out);
    for (int i = 0; i < n; i++) begin
      if (pick(25)) addr = 2'($urandom);
      cs_n = !pick(85);
      rd_n = !pick(p_rd);
      wr_n = !pick(p_wr);
      oe_n = !pick(70);
      din  = $urandom;
      for (int t = 0; t < 4; t++) begin
        ep_in_valid[t]            = pick(p_in);
        ep_in_data[t*DW +: DW]    = $urandom;
        ep_out_ready[t]           = pick(p_out);
      end
      step("RND");
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5113));
    rst_n = 1'b0;
    addr  = 2'd0;
    idle_inputs();
    model_reset();
    repeat (3) @(negedge clk);
    // R9: state held in reset
    check_all("R9 reset");
    rst_n = 1'b1;

    // R7 R3: fill write thread 1 past capacity with the drain stalled
    addr = 2'd1;
    repeat (3) step("R1 settle");
    cs_n = 1'b0; oe_n = 1'b0; wr_n = 1'b0;
    for (int i = 0; i <= DEPTH; i++) begin
      din = 32'hA500_0000 + i;
      step("R3 fill");
    end
    wr_n = 1'b1;
    chk(err_sticky[1] == 1'b1, "R7 overflow sets error", DW'(err_sticky[1]), 32'd1);
    chk(flag0 == 1'b0, "R4 full write thread", DW'(flag0), 32'd0);
    chk(flag1 == 1'b0, "R5 no free space below watermark", DW'(flag1), 32'd0);
    // R7: read strobe on write thread is ignored
    rd_n = 1'b0;
    step("R7 read on write thread");
    rd_n = 1'b1;
    // R11 R3: drain in order
    ep_out_ready[1] = 1'b1;
    repeat (DEPTH + 1) step("R11 drain");
    ep_out_ready[1] = 1'b0;

    // R1: switch to read thread 0 and watch the three-edge lag
    ep_in_valid[0] = 1'b1; ep_in_data[31:0] = 32'h0C0F_FEE0;
    step("R10 fill thr0");
    ep_in_valid[0] = 1'b0;
    addr = 2'd0;
    step("R1 lag1");
    chk(dout == '0, "R1 dout before lag", dout, 32'd0);
    step("R1 lag2");
    chk(dout == '0, "R1 dout before lag", dout, 32'd0);
    step("R1 lag3");
    chk(dout == 32'h0C0F_FEE0, "R1 dout after lag", dout, 32'h0C0F_FEE0);
    // R7: read past empty
    rd_n = 1'b0;
    step("R2 pop");
    step("R7 underflow");
    chk(err_sticky[0] == 1'b1, "R7 underflow sets error", DW'(err_sticky[0]), 32'd1);
    rd_n = 1'b1;

    random_phase(1500, 10, 60, 80, 10);
    random_phase(1500, 70, 10, 10, 80);
    random_phase(2000, 40, 40, 50, 50);
    random_phase(1000, 5, 5, 95, 95);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule